// File: doc/BRIEF.md
# Dual-Clock FIFO with Standard and Fall-Through Modes

This block is a first-in first-out buffer with independent write and read clocks. A strap input, sampled only while master reset is held, chooses one of two behaviours. In standard mode, a read request loads the next stored word into the output register, and the two flag outputs report full and empty as active-low signals. In fall-through mode, the block moves the oldest stored word into the output register without waiting for a request. The flags then report write space and output readiness, and the output register counts as one extra slot of capacity.

The read port has a chip select, sampled on the read clock, which gates the output drive indication. It also qualifies reads, but it has no effect on flags or on fall-through. A separate output enable forces the drive indication off at once. Partial reset empties the buffer and restores the flags but keeps the captured mode. Pointers cross between the clocks as Gray codes through two-flop synchronisers. Each flag is therefore pessimistic for a few cycles after activity on the opposite side.

Top module: `dmf_fifo`

## Requirements
- R1: In standard mode (`mode_strap` = 0 at master reset), `wr_flag` is 1 while space remains and goes 0 once DEPTH words are stored with no reads. A write (`wr_en_n` = 0 on a `wclk` edge) attempted while full stores nothing.
- R2: In fall-through mode (`mode_strap` = 1 at master reset), `wr_flag` is 0 while space remains and goes 1 after DEPTH+1 writes with no reads, counting the word held in the output register. Further writes are dropped.
- R3: In standard mode, `rd_flag` is 0 while no word is stored. A read attempted while empty leaves `rd_data` unchanged and consumes nothing.
- R4: In standard mode, a `rclk` edge with `rd_cs_n` = 0 and `rd_en_n` = 0 on a non-empty buffer loads the oldest word into `rd_data`. Words come out in write order.
- R5: In fall-through mode, the first word written into an empty buffer appears on `rd_data` with `rd_flag` = 0 without any read. This happens whatever the level of `rd_cs_n`.
- R6: In fall-through mode, a read edge with `rd_flag` = 0 replaces `rd_data` with the next word. After the last word is read, `rd_flag` returns to 1 and `rd_data` keeps that last word.
- R7: Outside reset, `rd_drv` follows the inverse of `rd_cs_n` as sampled on the previous `rclk` edge, provided `rd_oe_n` = 0. An edge with `rd_cs_n` = 1 performs no read even when `rd_en_n` = 0. `rd_en_n` is held at 1 on the edge where `rd_cs_n` is first seen low.
- R8: `rd_oe_n` = 1 drives `rd_drv` to 0 with no clock. During either reset, `rd_drv` equals the inverse of `rd_oe_n`, and it stays so until the first `rclk` edge after reset ends.
- R9: Partial reset empties the buffer and resets both flags to the idle values of the mode captured at master reset. `mode_strap` is ignored while partial reset is held.
- R10: Concurrent writes and reads in the two clock domains neither lose, duplicate nor reorder any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, held across several edges of both clocks |
| prst | input | 1 | Partial reset, active high, keeps the captured mode |
| mode_strap | input | 1 | Mode select captured at master reset: 0 standard, 1 fall-through |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | WIDTH | Write data word |
| wr_flag | output | 1 | Standard: 0 = full; fall-through: 0 = space available |
| rd_en_n | input | 1 | Read request, active low |
| rd_cs_n | input | 1 | Read chip select, active low, sampled on `rclk` |
| rd_oe_n | input | 1 | Output enable, active low, asynchronous |
| rd_data | output | WIDTH | Output register contents |
| rd_flag | output | 1 | Standard: 0 = empty; fall-through: 0 = output word ready |
| rd_drv | output | 1 | Output drive indication, 1 when the data bus would be driven |

## Verification
The bench probes exact capacity in both modes: full must appear at DEPTH words in standard mode and only at DEPTH+1 in fall-through mode. A design that leaves the output register out of the count, or counts it twice, trips one boundary or the other. It then checks that an overfull write and an empty read leave no trace. A stray stored word would surface as a non-empty flag or a changed output. For fall-through mode, it drives chip select high while the first word arrives, so a design that gated fall-through with select would show a stale output. It checks that partial reset with the strap flipped still gives fall-through idle flag values and discards old contents. A final streamed transfer under flag-driven pacing on both clocks catches pointer synchronisation errors as lost or reordered words.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    function automatic fifo_mode_e mode_of(logic strap);
        return strap ? MODE_FWFT : MODE_STD;
    endfunction

    // Write-side pin: standard reports "not full" high, fall-through reports "full" high.
    function automatic logic wr_flag_of(fifo_mode_e m, logic full);
        return (m == MODE_FWFT) ? full : !full;
    endfunction

    // Read-side pin: standard reports "not empty" high, fall-through reports "no word ready" high.
    function automatic logic rd_flag_of(fifo_mode_e m, logic avail);
        return (m == MODE_FWFT) ? !avail : avail;
    endfunction

endpackage

// File: rtl/dmf_sync2.sv
module dmf_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
    parameter int W  = 20,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int N = 1 << AW;

    logic [W-1:0] store [N];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dmf_wr_ctl.sv
module dmf_wr_ctl
    import dmf_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mrst,
    input  logic          mode_strap,
    input  logic          wr_en_n,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-2:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          wr_fire,
    output logic          wr_flag
);
    fifo_mode_e    mode_q, mode_eff;
    logic [PW-1:0] wbin, wbin_nx;
    logic          full, flag_s1;

    assign mode_eff = mrst ? mode_of(mode_strap) : mode_q;
    // Full: Gray pointers differ only in the two top bits.
    assign full     = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign wr_fire  = !wr_en_n && !full;
    assign wbin_nx  = wbin + PW'(wr_fire);
    assign waddr    = wbin[PW-2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= mode_eff;
            wbin    <= '0;
            wgray   <= '0;
            flag_s1 <= wr_flag_of(mode_eff, 1'b0);
            wr_flag <= wr_flag_of(mode_eff, 1'b0);
        end else begin
            wbin    <= wbin_nx;
            wgray   <= wbin_nx ^ (wbin_nx >> 1);
            flag_s1 <= wr_flag_of(mode_q, full);
            wr_flag <= flag_s1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_n && full) |=> $stable(wbin)); // R1
    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1); // R10
endmodule

// File: rtl/dmf_rd_ctl.sv
module dmf_rd_ctl
    import dmf_pkg::*;
#(
    parameter int PW = 5,
    parameter int W  = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mrst,
    input  logic          mode_strap,
    input  logic          rd_en_n,
    input  logic          rd_cs_n,
    input  logic          rd_oe_n,
    input  logic [PW-1:0] wgray_s,
    input  logic [W-1:0]  mem_rdata,
    output logic [PW-2:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [W-1:0]  rd_data,
    output logic          rd_flag,
    output logic          rd_drv
);
    fifo_mode_e    mode_q, mode_eff;
    logic [PW-1:0] rbin, rbin_nx;
    logic          empty, rd_sel, rd_fire, pop;
    logic          ovalid, ovalid_nx, flag_s1, cs_q;

    assign mode_eff = mrst ? mode_of(mode_strap) : mode_q;
    assign empty    = (rgray == wgray_s);
    assign rd_sel   = !rd_cs_n && !rd_en_n;
    assign raddr    = rbin[PW-2:0];

    always_comb begin
        if (mode_q == MODE_FWFT) begin
            rd_fire   = rd_sel && ovalid;
            pop       = !empty && (!ovalid || rd_fire);
            ovalid_nx = pop || (ovalid && !rd_fire);
        end else begin
            rd_fire   = rd_sel && !empty;
            pop       = rd_fire;
            ovalid_nx = 1'b0;
        end
    end

    assign rbin_nx = rbin + PW'(pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= mode_eff;
            rbin    <= '0;
            rgray   <= '0;
            ovalid  <= 1'b0;
            flag_s1 <= rd_flag_of(mode_eff, 1'b0);
            rd_flag <= rd_flag_of(mode_eff, 1'b0);
            cs_q    <= 1'b1;
        end else begin
            rbin    <= rbin_nx;
            rgray   <= rbin_nx ^ (rbin_nx >> 1);
            ovalid  <= ovalid_nx;
            flag_s1 <= rd_flag_of(mode_q, !empty);
            rd_flag <= (mode_q == MODE_FWFT) ? rd_flag_of(mode_q, ovalid_nx) : flag_s1;
            cs_q    <= !rd_cs_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && pop) rd_data <= mem_rdata;
    end

    assign rd_drv = !rd_oe_n && (rst || cs_q);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STD && rd_sel && empty) |=> $stable(rbin)); // R3
    AST_FWFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FWFT && ovalid && !rd_sel) |=> $stable(rd_data)); // R6
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rd_cs_n |=> !rd_drv); // R7
    AST_REN_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_cs_n) |-> rd_en_n); // R7
    AST_PRST_KEEP: assert property (@(posedge clk) disable iff (mrst)
        (rst && mode_q == MODE_FWFT) |=> rd_flag); // R9
    AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1); // R10
endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo
    import dmf_pkg::*;
#(
    parameter int WIDTH = 20,
    parameter int DEPTH = 16
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             mode_strap,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_flag,
    input  logic             rd_en_n,
    input  logic             rd_cs_n,
    input  logic             rd_oe_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_flag,
    output logic             rd_drv
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          rst_any, wr_fire;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [WIDTH-1:0] mem_rdata;

    assign rst_any = mrst || prst;

    dmf_wr_ctl #(.PW(PW)) u_wr (
        .clk(wclk), .rst(rst_any), .mrst(mrst), .mode_strap(mode_strap),
        .wr_en_n(wr_en_n), .rgray_s(rgray_s), .waddr(waddr), .wgray(wgray),
        .wr_fire(wr_fire), .wr_flag(wr_flag)
    );

    dmf_ram #(.W(WIDTH), .AW(AW)) u_ram (
        .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    dmf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rst_any), .d(wgray), .q(wgray_s));
    dmf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(rst_any), .d(rgray), .q(rgray_s));

    dmf_rd_ctl #(.PW(PW), .W(WIDTH)) u_rd (
        .clk(rclk), .rst(rst_any), .mrst(mrst), .mode_strap(mode_strap),
        .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .rd_oe_n(rd_oe_n),
        .wgray_s(wgray_s), .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray),
        .rd_data(rd_data), .rd_flag(rd_flag), .rd_drv(rd_drv)
    );
endmodule

// File: tb/dmf_fifo_tb_top.sv
`timescale 1ns/1ps
module dmf_fifo_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
    localparam int WIDTH = 20;
    localparam int DEPTH = 16;

    logic wclk = 0, rclk = 0;
    logic mrst = 1, prst = 0, mode_strap = 0;
    logic wr_en_n = 1, rd_en_n = 1, rd_cs_n = 1, rd_oe_n = 0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic wr_flag, rd_flag, rd_drv;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2)  wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    dmf_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut_i (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .mode_strap(mode_strap),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .wr_flag(wr_flag),
        .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .rd_oe_n(rd_oe_n),
        .rd_data(rd_data), .rd_flag(rd_flag), .rd_drv(rd_drv)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge rclk);
    endtask

    task automatic do_reset(bit partial, bit strap);
        @(negedge wclk);
        mode_strap = strap;
        if (partial) prst = 1; else mrst = 1;
        repeat (6) @(negedge wclk);
        mrst = 0; prst = 0;
    endtask

    task automatic push(logic [WIDTH-1:0] w);
        @(negedge wclk);
        wr_en_n = 0; wr_data = w;
        @(negedge wclk);
        wr_en_n = 1;
    endtask

    task automatic read_edge();
        @(negedge rclk); rd_en_n = 0;
        @(negedge rclk); rd_en_n = 1;
    endtask

    task automatic select_on();
        @(negedge rclk); rd_en_n = 1; rd_cs_n = 0;
        @(negedge rclk);
    endtask

    task automatic t_reset_drive();
        rd_cs_n = 1; rd_oe_n = 0;
        @(negedge wclk); mrst = 1; mode_strap = 0;
        repeat (4) @(negedge wclk);
        chk("R8 drive during reset", rd_drv, 1);
        mrst = 0;
        #1 chk("R8 drive held until rclk edge", rd_drv, 1);
        @(posedge rclk); #1;
        chk("R7 select high releases drive", rd_drv, 0);
        chk("R1 reset standard wr_flag", wr_flag, 1);
        chk("R3 reset standard rd_flag", rd_flag, 0);
        select_on();
        chk("R7 select low enables drive", rd_drv, 1);
        rd_oe_n = 1;
        #1 chk("R8 output enable forces off", rd_drv, 0);
        rd_oe_n = 0;
        #1 chk("R8 output enable restored", rd_drv, 1);
    endtask

    task automatic t_std_fill_drain();
        for (int i = 0; i < DEPTH - 1; i++) push(20'h100 + i);
        settle();
        chk("R1 one slot left", wr_flag, 1);
        push(20'h100 + DEPTH - 1);
        settle();
        chk("R1 full after DEPTH writes", wr_flag, 0);
        push(20'hBADBA);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            read_edge();
            chk("R4 standard order", rd_data, 20'h100 + i);
        end
        settle();
        chk("R3 empty after drain (overfull write dropped, R1)", rd_flag, 0);
        chk("R1 not full after drain", wr_flag, 1);
        read_edge();
        settle();
        chk("R3 read on empty keeps data", rd_data, 20'h100 + DEPTH - 1);
    endtask

    task automatic t_std_select();
        push(20'h0A5A5);
        settle();
        @(negedge rclk); rd_cs_n = 1;
        read_edge();
        settle();
        chk("R7 no read with select high", rd_data, 20'h100 + DEPTH - 1);
        chk("R7 word still stored", rd_flag, 1);
        select_on();
        read_edge();
        chk("R4 read after select", rd_data, 20'h0A5A5);
    endtask

    task automatic t_fwft();
        do_reset(0, 1);
        @(negedge rclk); rd_cs_n = 1;
        settle();
        chk("R2 fwft reset wr_flag", wr_flag, 0);
        chk("R6 fwft reset rd_flag", rd_flag, 1);
        push(20'h200);
        settle();
        chk("R5 fall-through flag", rd_flag, 0);
        chk("R5 fall-through data with select high", rd_data, 20'h200);
        chk("R7 drive off with select high", rd_drv, 0);
        for (int i = 1; i < DEPTH; i++) push(20'h200 + i);
        settle();
        chk("R2 space left at DEPTH writes", wr_flag, 0);
        push(20'h200 + DEPTH);
        settle();
        chk("R2 full at DEPTH+1 writes", wr_flag, 1);
        push(20'hBADBA);
        settle();
        select_on();
        for (int i = 0; i <= DEPTH; i++) begin
            chk("R6 fwft order", rd_data, 20'h200 + i);
            read_edge();
        end
        settle();
        chk("R6 not ready after last read", rd_flag, 1);
        chk("R6 last word held (R2 extra dropped)", rd_data, 20'h200 + DEPTH);
        read_edge();
        settle();
        chk("R6 read with nothing ready", rd_data, 20'h200 + DEPTH);
    endtask

    task automatic t_prst();
        for (int i = 0; i < 3; i++) push(20'h300 + i);
        settle();
        do_reset(1, 0);
        settle();
        chk("R9 fwft rd_flag after partial reset", rd_flag, 1);
        chk("R9 fwft wr_flag after partial reset", wr_flag, 0);
        push(20'h3F0F0);
        settle();
        chk("R9 old contents cleared", rd_data, 20'h3F0F0);
        chk("R9 mode kept, word fell through", rd_flag, 0);
    endtask

    task automatic t_stream();
        do_reset(0, 0);
        select_on();
        settle();
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    while (wr_flag !== 1'b1) @(negedge wclk);
                    push(20'h400 + i);
                    repeat (2) @(negedge wclk);
                end
            end
            begin
                for (int i = 0; i < 40; i++) begin
                    while (rd_flag !== 1'b1) @(negedge rclk);
                    read_edge();
                    chk("R10 streamed word", rd_data, 20'h400 + i);
                    repeat (4) @(negedge rclk);
                end
            end
        join
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge wclk);
        t_reset_drive();
        t_std_fill_drain();
        t_std_select();
        t_fwft();
        t_prst();
        t_stream();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule